// File: doc/BRIEF.md
# Operand Address Generator for Signal-Processing Loops

This block supplies one operand address per clock to a signal-processing datapath. Address updates run beside the arithmetic, so the datapath never waits for address math. A single pointer can step in one of three ways. The first is plain post-increment by a signed step. The second is a circular buffer that wraps at a programmable window with no software compare. The third is bit-reversed indexing for radix-2 FFT passes.

A load strobe captures the configuration: mode, base, buffer length, step and FFT order. The same strobe places the pointer at the base and clears the index counter. After that, each advance strobe moves to the next address. The new address is visible on the output in the cycle after the advance edge. The configuration stays fixed until the next load, so the input configuration pins may change freely in between.

Top module: `agu_top`

## Requirements
- R1: While reset is high, the output address becomes 0 at the clock edge, and the configuration returns to linear mode.
- R2: A load sets the pointer to `base` and clears the index counter. In linear and circular modes the next output is `base`. In bit-reversed mode it is `base` with its low k bits cleared. A load overrides an advance given in the same cycle.
- R3: Mode encodings are 0 linear, 1 circular, 2 bit-reversed, and 3 treated as linear. In linear mode each advance adds the two's-complement `step` to the address modulo 2^16.
- R4: In circular mode with a nonzero length and a non-negative step, if pointer plus step is at or above base plus length, the length is subtracted.
- R5: In circular mode with a negative step, if pointer plus step falls below base, the length is added. This holds provided the step magnitude does not exceed the length.
- R6: In circular mode a length of zero disables wrapping, and the pointer moves as in linear mode.
- R7: In bit-reversed mode the low k address bits are the k-bit reversal of an index counter. Each advance increments that counter modulo 2^k. Address bits k and above come from `base`.
- R8: The FFT order k is the `fft_log2` value clamped to the range 1 to 10: 0 acts as 1, and values above 10 act as 10.
- R9: With neither load nor advance, the address holds, even when the configuration inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture configuration and initialise pointer and counter |
| advance | input | 1 | Step to the next address |
| mode | input | 2 | 0 linear, 1 circular, 2 bit-reversed, 3 linear |
| base | input | 16 | Start address / window base / upper address bits |
| length | input | 16 | Circular window length (0 disables wrapping) |
| step | input | 16 | Signed pointer increment |
| fft_log2 | input | 4 | FFT order k (log2 of points) |
| addr | output | 16 | Current operand address |

## Verification
Linear runs use a positive step and a negative step that crosses address zero. These show whether the modulo-2^16 arithmetic sign-extends the step. Circular runs use a step smaller than the window, a negative step, and a step equal to the window. The outputs are compared with a modulo reference, which separates wrap at the top from wrap at the base and shows an off-by-one at the boundary. Bit-reversed runs at orders 1, 3 and 10 are compared with a bit-reverse reference over a full traversal. These runs expose faults in counter wrap, reversal width and the preservation of the upper bits. Directed cases cover order clamping, zero length, load priority and holding.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int AGU_ADDR_W  = 16;
    localparam int AGU_ORD_MAX = 10;
    localparam int AGU_ORD_W   = 4;

    typedef enum logic [1:0] {
        AGU_LINEAR = 2'd0,
        AGU_CIRC   = 2'd1,
        AGU_BREV   = 2'd2,
        AGU_RSVD   = 2'd3
    } agu_mode_e;

    typedef struct packed {
        agu_mode_e               mode;
        logic [AGU_ADDR_W-1:0]   base;
        logic [AGU_ADDR_W-1:0]   len;
        logic [AGU_ADDR_W-1:0]   step;
        logic [AGU_ORD_W-1:0]    order;
    } agu_cfg_t;

    function automatic logic [AGU_ORD_W-1:0] clamp_order(input logic [AGU_ORD_W-1:0] o);
        if (o < AGU_ORD_W'(1))           return AGU_ORD_W'(1);
        if (o > AGU_ORD_W'(AGU_ORD_MAX)) return AGU_ORD_W'(AGU_ORD_MAX);
        return o;
    endfunction

    function automatic logic [AGU_ORD_MAX-1:0] order_mask(input logic [AGU_ORD_W-1:0] o);
        logic [AGU_ORD_MAX:0] one;
        logic [AGU_ORD_MAX:0] m;
        one = (AGU_ORD_MAX+1)'(1);
        m   = (one << o) - one;
        return m[AGU_ORD_MAX-1:0];
    endfunction

endpackage

// File: rtl/agu_step_unit.sv
module agu_step_unit #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] len,
    input  logic [AW-1:0] step,
    input  logic          circ_en,
    output logic [AW-1:0] nxt
);
    localparam int WW = AW + 2;

    logic signed [WW-1:0] s_ptr, s_base, s_len, s_step, s_sum, s_lim, s_res;

    always_comb begin
        s_ptr  = signed'({2'b00, ptr});
        s_base = signed'({2'b00, base});
        s_len  = signed'({2'b00, len});
        s_step = signed'({{2{step[AW-1]}}, step});
        s_sum  = s_ptr + s_step;
        s_lim  = s_base + s_len;
        s_res  = s_sum;
        if (circ_en && (len != '0)) begin
            if (!step[AW-1] && (s_sum >= s_lim))
                s_res = s_sum - s_len;
            else if (step[AW-1] && (s_sum < s_base))
                s_res = s_sum + s_len;
        end
        nxt = s_res[AW-1:0];
    end
endmodule

// File: rtl/agu_bitrev.sv
module agu_bitrev #(
    parameter int AW = 16,
    parameter int LM = 10,
    parameter int OW = 4
) (
    input  logic [LM-1:0] cnt,
    input  logic [AW-1:0] base,
    input  logic [OW-1:0] order,
    output logic [AW-1:0] addr
);
    for (genvar i = 0; i < LM; i++) begin : g_low
        always_comb begin
            addr[i] = base[i];
            if (i < int'(order)) begin
                for (int j = 0; j < LM; j++) begin
                    if (int'(order) - 1 - i == j) addr[i] = cnt[j];
                end
            end
        end
    end
    for (genvar i = LM; i < AW; i++) begin : g_high
        assign addr[i] = base[i];
    end
endmodule

// File: rtl/agu_top.sv
module agu_top
    import agu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  advance,
    input  logic [1:0]            mode,
    input  logic [AGU_ADDR_W-1:0] base,
    input  logic [AGU_ADDR_W-1:0] length,
    input  logic [AGU_ADDR_W-1:0] step,
    input  logic [AGU_ORD_W-1:0]  fft_log2,
    output logic [AGU_ADDR_W-1:0] addr
);
    agu_cfg_t                cfg;
    logic [AGU_ADDR_W-1:0]   ptr;
    logic [AGU_ORD_MAX-1:0]  cnt;
    logic [AGU_ADDR_W-1:0]   ptr_nxt;
    logic [AGU_ADDR_W-1:0]   rev_addr;

    agu_step_unit #(.AW(AGU_ADDR_W)) i_step (
        .ptr     (ptr),
        .base    (cfg.base),
        .len     (cfg.len),
        .step    (cfg.step),
        .circ_en (cfg.mode == AGU_CIRC),
        .nxt     (ptr_nxt)
    );

    agu_bitrev #(.AW(AGU_ADDR_W), .LM(AGU_ORD_MAX), .OW(AGU_ORD_W)) i_rev (
        .cnt   (cnt),
        .base  (cfg.base),
        .order (cfg.order),
        .addr  (rev_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '{mode: AGU_LINEAR, base: '0, len: '0, step: '0, order: AGU_ORD_W'(1)};
            ptr <= '0;
            cnt <= '0;
        end else if (load) begin
            cfg.mode  <= agu_mode_e'(mode);
            cfg.base  <= base;
            cfg.len   <= length;
            cfg.step  <= step;
            cfg.order <= clamp_order(fft_log2);
            ptr       <= base;
            cnt       <= '0;
        end else if (advance) begin
            if (cfg.mode == AGU_BREV)
                cnt <= (cnt + 1'b1) & order_mask(cfg.order);
            else
                ptr <= ptr_nxt;
        end
    end

    assign addr = (cfg.mode == AGU_BREV) ? rev_addr : ptr;

endmodule

// File: rtl/agu_chk.sv
module agu_chk
    import agu_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  load,
    input logic                  advance,
    input logic [1:0]            in_mode,
    input logic [AGU_ADDR_W-1:0] in_base,
    input logic [AGU_ADDR_W-1:0] addr,
    input agu_cfg_t              cur_cfg
);
    logic in_win;
    always_comb
        in_win = (addr >= cur_cfg.base) &&
                 ({1'b0, addr} < ({1'b0, cur_cfg.base} + {1'b0, cur_cfg.len}));

    a_r2_load_base: assert property (@(posedge clk) disable iff (rst)
        (load && in_mode != 2'd2) |=> addr == $past(in_base));

    a_r2_load_brev_top: assert property (@(posedge clk) disable iff (rst)
        (load && in_mode == 2'd2) |=>
            addr[AGU_ADDR_W-1:AGU_ORD_MAX] == $past(in_base[AGU_ADDR_W-1:AGU_ORD_MAX]));

    a_r3_linear_step: assert property (@(posedge clk) disable iff (rst)
        (!load && advance && (cur_cfg.mode == AGU_LINEAR || cur_cfg.mode == AGU_RSVD))
            |=> addr == $past(addr + cur_cfg.step));

    a_r4_circ_window: assert property (@(posedge clk) disable iff (rst)
        (!load && cur_cfg.mode == AGU_CIRC && cur_cfg.len != '0 && in_win) |=> in_win);

    a_r7_brev_upper: assert property (@(posedge clk) disable iff (rst)
        (cur_cfg.mode == AGU_BREV) |->
            addr[AGU_ADDR_W-1:AGU_ORD_MAX] == cur_cfg.base[AGU_ADDR_W-1:AGU_ORD_MAX]);

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && !advance) |=> $stable(addr));
endmodule

bind agu_top agu_chk i_agu_chk (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .advance (advance),
    .in_mode (mode),
    .in_base (base),
    .addr    (addr),
    .cur_cfg (cfg)
);

// File: tb/test_agu_top.sv
`timescale 1ns/1ps
module test_agu_top;
    logic        clk = 1'b0;
    logic        rst, load, advance;
    logic [1:0]  mode;
    logic [15:0] base, length, step;
    logic [3:0]  fft_log2;
    logic [15:0] addr;
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    agu_top i_agu_top (
        .clk(clk), .rst(rst), .load(load), .advance(advance), .mode(mode),
        .base(base), .length(length), .step(step), .fft_log2(fft_log2), .addr(addr)
    );

    typedef struct packed {
        logic [1:0]  md;
        logic [15:0] bs;
        logic [15:0] ln;
        logic [15:0] st;
        logic [3:0]  ord;
        logic [11:0] n;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'h0100, 16'd0,  16'd3,    4'd0,  12'd10},
        '{2'd0, 16'h0010, 16'd0,  16'hFFFE, 4'd0,  12'd12},
        '{2'd1, 16'h0200, 16'd10, 16'd3,    4'd0,  12'd25},
        '{2'd1, 16'h0300, 16'd7,  16'hFFFE, 4'd0,  12'd20},
        '{2'd1, 16'h0400, 16'd5,  16'd5,    4'd0,  12'd8},
        '{2'd2, 16'h1234, 16'd0,  16'd0,    4'd3,  12'd16},
        '{2'd2, 16'h8000, 16'd0,  16'd0,    4'd10, 12'd1030},
        '{2'd2, 16'h00F0, 16'd0,  16'd0,    4'd1,  12'd4},
        '{2'd1, 16'h0500, 16'd0,  16'd7,    4'd0,  12'd6},
        '{2'd3, 16'h0040, 16'd0,  16'd1,    4'd0,  12'd4}
    };

    function automatic logic [15:0] ref_addr(vec_t v, int i);
        int k, c, r, off, s;
        logic [15:0] m;
        case (v.md)
            2'd2: begin
                k = (v.ord < 1) ? 1 : ((v.ord > 10) ? 10 : int'(v.ord));
                c = i % (1 << k);
                r = 0;
                for (int b = 0; b < k; b++) if (c[b]) r |= 1 << (k - 1 - b);
                m = 16'((1 << k) - 1);
                return (v.bs & ~m) | 16'(r);
            end
            2'd1: begin
                s = int'($signed(v.st));
                if (v.ln == 0) return 16'(int'(v.bs) + i * s);
                off = ((i * s) % int'(v.ln) + int'(v.ln)) % int'(v.ln);
                return 16'(int'(v.bs) + off);
            end
            default: return 16'(int'(v.bs) + i * int'($signed(v.st)));
        endcase
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_load(logic [1:0] md, logic [15:0] bs, logic [15:0] ln,
                           logic [15:0] st, logic [3:0] od, logic adv);
        mode = md; base = bs; length = ln; step = st; fft_log2 = od;
        load = 1'b1; advance = adv;
        @(negedge clk);
        load = 1'b0; advance = 1'b0;
    endtask

    task automatic do_adv();
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
    endtask

    task automatic do_idle();
        @(negedge clk);
    endtask

    function automatic string req_of(logic [1:0] md, logic [15:0] ln, logic [15:0] st);
        if (md == 2'd2) return "R7";
        if (md == 2'd1 && ln == 0) return "R6";
        if (md == 2'd1) return st[15] ? "R5" : "R4";
        return "R3";
    endfunction

    initial begin
        #1000000;
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; load = 0; advance = 0; mode = 0;
        base = 16'hABCD; length = 0; step = 0; fft_log2 = 0;
        repeat (3) @(negedge clk);
        chk("R1", addr, 16'h0000);
        advance = 1'b1;
        @(negedge clk);
        chk("R1", addr, 16'h0000);
        rst = 1'b0; advance = 1'b0;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            do_load(VECS[v].md, VECS[v].bs, VECS[v].ln, VECS[v].st, VECS[v].ord, 1'b0);
            chk("R2", addr, ref_addr(VECS[v], 0));
            for (int i = 1; i <= int'(VECS[v].n); i++) begin
                do_adv();
                chk(req_of(VECS[v].md, VECS[v].ln, VECS[v].st), addr, ref_addr(VECS[v], i));
            end
        end

        // R2: load wins over a simultaneous advance
        do_load(2'd0, 16'h0700, 16'd0, 16'd4, 4'd0, 1'b1);
        chk("R2", addr, 16'h0700);

        // R9: hold with changing configuration inputs
        do_load(2'd1, 16'h0600, 16'd6, 16'd4, 4'd0, 1'b0);
        do_adv(); do_adv();
        chk("R4", addr, 16'h0602);
        base = 16'h0F00; step = 16'd1; mode = 2'd2;
        do_idle(); do_idle();
        chk("R9", addr, 16'h0602);
        do_adv();
        chk("R9", addr, 16'h0600);

        // R8: order 0 acts as 1
        do_load(2'd2, 16'h00FF, 16'd0, 16'd0, 4'd0, 1'b0);
        chk("R8", addr, 16'h00FE);
        do_adv();
        chk("R8", addr, 16'h00FF);
        do_adv();
        chk("R8", addr, 16'h00FE);

        // R8: order 15 acts as 10
        do_load(2'd2, 16'hFFFF, 16'd0, 16'd0, 4'd15, 1'b0);
        chk("R8", addr, 16'hFC00);
        do_adv();
        chk("R8", addr, 16'hFE00);
        do_adv();
        chk("R8", addr, 16'hFD00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule